// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Encoder

This block is the shared interrupt logic of a two-channel serial controller. Each channel raises three pending sources: receive, transmit and external/status. A receive source can also be flagged as a special-receive condition. The block keeps the sources that an in-service level does not block and picks the one with the highest priority. It raises a request when the master enable and the daisy-chain enable-in allow it. It also forms an 8-bit vector by inserting a 3-bit source code into the stored base vector.

The vector-register read port selects its channel with `rd_ch_b_i`. A channel-B read returns the modified vector. A channel-A read returns the stored base unchanged. The pending-flags byte can be read only through channel A. On an acknowledge the block marks the winning source as in service and drives a vector, unless vector response is suppressed. A reset-highest-in-service command releases the highest level that is in service. The enable-out pin lets devices lower in the daisy chain raise their own requests.

Top module: `ivec_enc`

## Requirements
- R1: Sources are indexed as 0 B ext/status, 1 B transmit, 2 B receive, 3 A ext/status, 4 A transmit, 5 A receive. Priority from highest to lowest is 5, 4, 3, 2, 1, 0. The source codes are: 5 gives 6, 4 gives 4, 3 gives 5, 2 gives 2, 1 gives 0, 0 gives 1.
- R2: When source 5 wins and `spec_rx_i[1]` is set, the code is 7 instead of 6. When source 2 wins and `spec_rx_i[0]` is set, the code is 3 instead of 2.
- R3: When no source is pending above the in-service level, the code is 3.
- R4: When `rd_ch_b_i`=0, `rr2_o` equals `base_vec_i`. When `rd_ch_b_i`=1, `rr2_o` is the modified vector, whatever the value of `mic_i[0]`.
- R5: The modified vector depends on `mic_i[4]`. With `mic_i[4]`=0 it is {base[7:4], code[2:0], base[0]}. With `mic_i[4]`=1 it is {base[7], code[0], code[1], code[2], base[3:0]}.
- R6: `irq_o` is 1 exactly when `mic_i[3]` (master enable) is 1, `ien_i` is 1, and some pending source is not blocked by the in-service state.
- R7: An acknowledge is taken when `ack_i` and `irq_o` are both 1. It sets the in-service bit of the winning source. An in-service bit blocks its own source and every lower source, while higher sources can still request.
- R8: `clr_ius_i` clears only the highest set in-service bit. If an acknowledge is taken in the same cycle, its bit is set as well.
- R9: `vec_drv_o` is 1 when an acknowledge is taken and `mic_i[1]` (no vector) is 0. `ack_vec_o` is then the modified vector if `mic_i[0]` is 1, and the base vector otherwise. `ack_vec_o` is 0 whenever `vec_drv_o` is 0.
- R10: When `rd_ch_b_i`=0, `rr3_o` is {2'b00, src_pend_i}, with the sources unmasked and in the bit order of R1. When `rd_ch_b_i`=1, `rr3_o` is 0.
- R11: `ieo_o` is 1 exactly when `ien_i` is 1, `mic_i[2]` (disable lower chain) is 0, no in-service bit is set, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pend_i | input | 6 | Pending sources, indexed as in R1 |
| spec_rx_i | input | 2 | Special-receive flags: bit 0 channel B, bit 1 channel A |
| base_vec_i | input | 8 | Stored base vector |
| mic_i | input | 5 | Master control: 0 include status, 1 no vector, 2 disable lower chain, 3 master enable, 4 status high |
| ien_i | input | 1 | Daisy-chain enable-in |
| ack_i | input | 1 | Acknowledge cycle |
| clr_ius_i | input | 1 | Reset highest in-service command |
| rd_ch_b_i | input | 1 | Read channel select, 1 = channel B |
| irq_o | output | 1 | Interrupt request |
| ieo_o | output | 1 | Daisy-chain enable-out |
| vec_drv_o | output | 1 | Vector driven on this acknowledge |
| ack_vec_o | output | 8 | Acknowledge vector |
| rr2_o | output | 8 | Vector register read data |
| rr3_o | output | 8 | Pending-flags read data |

## Verification
An acknowledge and a reset-highest-in-service command can arrive in the same cycle. The in-service state then loses its highest level and gains the new winner's level at the same edge. The bench provokes this directly, with one level in service and a higher source pending. It also lets random traffic raise both strobes together. A behavioural model with its own loop-based in-service list predicts the next request, enable-out and vector on every clock, so a wrong merge shows up at once as a wrong request or a wrong code.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int NSRC   = 6;
  localparam int CODE_W = 3;
  localparam int VEC_W  = 8;
  localparam int IDX_W  = $clog2(NSRC);

  typedef struct packed {
    logic stat_hi;
    logic mie;
    logic dlc;
    logic no_vec;
    logic inc_stat;
  } mic_t;

  localparam logic [CODE_W-1:0] CODE_IDLE = 3'd3;

  function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx,
                                                 input logic [1:0] spec);
    case (idx)
      3'd5:    src_code = spec[1] ? 3'd7 : 3'd6;
      3'd4:    src_code = 3'd4;
      3'd3:    src_code = 3'd5;
      3'd2:    src_code = spec[0] ? 3'd3 : 3'd2;
      3'd1:    src_code = 3'd0;
      default: src_code = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/ivec_prio.sv
module ivec_prio
  import ivec_pkg::*;
(
  input  logic [NSRC-1:0]   pend_i,
  input  logic [NSRC-1:0]   ius_i,
  input  logic [1:0]        spec_i,
  output logic [NSRC-1:0]   win_oh_o,
  output logic              win_vld_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  req;
  logic [IDX_W-1:0] win_idx;

  // a level in service blocks itself and everything below it
  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = ~|ius_i[NSRC-1:g];
  end

  assign req = pend_i & elig;

  always_comb begin
    win_oh_o  = '0;
    win_vld_o = 1'b0;
    win_idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && !win_vld_o) begin
        win_vld_o   = 1'b1;
        win_oh_o[i] = 1'b1;
        win_idx     = IDX_W'(i);
      end
    end
  end

  assign code_o = win_vld_o ? src_code(win_idx, spec_i) : CODE_IDLE;
endmodule

// File: rtl/ivec_ius.sv
module ivec_ius
  import ivec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            clr_i,
  input  logic [NSRC-1:0] win_oh_i,
  output logic [NSRC-1:0] ius_o
);
  logic [NSRC-1:0] ius_q;
  logic [NSRC-1:0] top_oh;

  always_comb begin
    top_oh = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (ius_q[i] && (top_oh == '0)) top_oh[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ius_q <= '0;
    else ius_q <= (ius_q & ~(clr_i ? top_oh : '0)) | (take_i ? win_oh_i : '0);
  end

  assign ius_o = ius_q;

  p_ius_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> |(ius_q & $past(win_oh_i)));

  p_ius_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !take_i && |ius_q) |=> ($countones(ius_q) == $countones($past(ius_q)) - 1));

  p_ius_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !take_i) |=> $stable(ius_q));
endmodule

// File: rtl/ivec_fmt.sv
module ivec_fmt
  import ivec_pkg::*;
(
  input  logic [VEC_W-1:0]  base_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              stat_hi_i,
  output logic [VEC_W-1:0]  vec_o
);
  always_comb begin
    vec_o = base_i;
    if (stat_hi_i) begin
      for (int b = 0; b < CODE_W; b++) vec_o[6-b] = code_i[b]; // reversed order
    end else begin
      vec_o[3:1] = code_i;
    end
  end
endmodule

// File: rtl/ivec_enc.sv
module ivec_enc
  import ivec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_pend_i,
  input  logic [1:0]       spec_rx_i,
  input  logic [VEC_W-1:0] base_vec_i,
  input  logic [4:0]       mic_i,
  input  logic             ien_i,
  input  logic             ack_i,
  input  logic             clr_ius_i,
  input  logic             rd_ch_b_i,
  output logic             irq_o,
  output logic             ieo_o,
  output logic             vec_drv_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic [VEC_W-1:0] rr2_o,
  output logic [VEC_W-1:0] rr3_o
);
  mic_t              mic;
  logic [NSRC-1:0]   ius;
  logic [NSRC-1:0]   win_oh;
  logic              win_vld;
  logic [CODE_W-1:0] code;
  logic [VEC_W-1:0]  mod_vec;
  logic              take;

  assign mic = mic_t'(mic_i);

  ivec_prio i_prio (
    .pend_i   (src_pend_i),
    .ius_i    (ius),
    .spec_i   (spec_rx_i),
    .win_oh_o (win_oh),
    .win_vld_o(win_vld),
    .code_o   (code)
  );

  ivec_ius i_ius (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .clr_i   (clr_ius_i),
    .win_oh_i(win_oh),
    .ius_o   (ius)
  );

  ivec_fmt i_fmt (
    .base_i   (base_vec_i),
    .code_i   (code),
    .stat_hi_i(mic.stat_hi),
    .vec_o    (mod_vec)
  );

  assign irq_o     = mic.mie & ien_i & win_vld;
  assign take      = ack_i & irq_o;
  assign ieo_o     = ien_i & ~mic.dlc & ~|ius & ~irq_o;
  assign vec_drv_o = take & ~mic.no_vec;
  assign ack_vec_o = vec_drv_o ? (mic.inc_stat ? mod_vec : base_vec_i) : '0;
  assign rr2_o     = rd_ch_b_i ? mod_vec : base_vec_i;
  assign rr3_o     = rd_ch_b_i ? '0 : {{(VEC_W-NSRC){1'b0}}, src_pend_i};

  p_irq_win_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(src_pend_i & win_oh));

  p_idle_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && ien_i && mic.mie && rd_ch_b_i && !mic.stat_hi) |-> (rr2_o[3:1] == CODE_IDLE));

  p_chan_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ch_b_i |-> (rr2_o == base_vec_i));

  p_chain_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !ieo_o);

  p_no_vec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mic.no_vec |-> !vec_drv_o);
endmodule

// File: tb/test_ivec_enc.sv
module test_ivec_enc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] src_pend_i = '0;
  logic [1:0] spec_rx_i = '0;
  logic [7:0] base_vec_i = '0;
  logic [4:0] mic_i = '0;
  logic       ien_i = 1'b1;
  logic       ack_i = 1'b0;
  logic       clr_ius_i = 1'b0;
  logic       rd_ch_b_i = 1'b0;
  logic       irq_o, ieo_o, vec_drv_o;
  logic [7:0] ack_vec_o, rr2_o, rr3_o;

  int total = 0;
  int bad = 0;
  bit [5:0] m_ius = '0;

  always #10 clk_i = ~clk_i;

  ivec_enc i_ivec_enc (.*);

  function automatic int m_win(bit [5:0] p, bit [5:0] s);
    for (int i = 5; i >= 0; i--) begin
      bit blk = 0;
      for (int j = i; j <= 5; j++) if (s[j]) blk = 1;
      if (!blk && p[i]) return i;
    end
    return -1;
  endfunction

  function automatic bit [2:0] m_code(int w, bit [1:0] sp);
    case (w)
      5: return sp[1] ? 3'd7 : 3'd6;
      4: return 3'd4;
      3: return 3'd5;
      2: return sp[0] ? 3'd3 : 3'd2;
      1: return 3'd0;
      0: return 3'd1;
      default: return 3'd3;
    endcase
  endfunction

  function automatic bit [7:0] m_vec(bit [7:0] b, bit [2:0] c, bit hi);
    if (hi) return {b[7], c[0], c[1], c[2], b[3:0]};
    return {b[7:4], c, b[0]};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // compare every output against the model, then advance the model one edge
  task automatic step(bit [5:0] p, bit [1:0] sp, bit [7:0] b, bit [4:0] m,
                      bit ie, bit ak, bit cl, bit chb);
    int w;
    bit [2:0] c;
    bit [7:0] mv;
    bit irq, take, drv;
    bit [5:0] nx;
    src_pend_i = p; spec_rx_i = sp; base_vec_i = b; mic_i = m;
    ien_i = ie; ack_i = ak; clr_ius_i = cl; rd_ch_b_i = chb;
    #2;
    w    = m_win(p, m_ius);
    c    = m_code(w, sp);
    mv   = m_vec(b, c, m[4]);
    irq  = m[3] && ie && (w >= 0);
    take = ak && irq;
    drv  = take && !m[1];
    chk("R6 irq", 8'(irq_o), 8'(irq));
    chk("R11 ieo", 8'(ieo_o), 8'(ie && !m[2] && (m_ius == 0) && !irq));
    chk("R9 vec_drv", 8'(vec_drv_o), 8'(drv));
    chk("R9 ack_vec", ack_vec_o, drv ? (m[0] ? mv : b) : 8'h00);
    chk("R1 R2 R3 R4 R5 rr2", rr2_o, chb ? mv : b);
    chk("R10 rr3", rr3_o, chb ? 8'h00 : {2'b00, p});
    nx = m_ius;
    if (cl) begin
      for (int i = 5; i >= 0; i--) if (nx[i]) begin nx[i] = 0; break; end
    end
    if (take) nx[w] = 1'b1;
    @(posedge clk_i);
    m_ius = nx;
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    // reset state
    step(6'h00, 2'b00, 8'hA5, 5'h08, 1, 0, 0, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(6'h00, 2'b00, 8'hA5, 5'h08, 1, 0, 0, 1); // R3 idle code
    // R1: each single source, channel B read, low and high placement
    for (int i = 0; i < 6; i++) begin
      step(6'(1 << i), 2'b00, 8'h00, 5'h08, 1, 0, 0, 1);
      step(6'(1 << i), 2'b00, 8'hFF, 5'h18, 1, 0, 0, 1); // R5
    end
    // R1 priority with all pending, then dropping the top one by one
    step(6'h3F, 2'b00, 8'h81, 5'h08, 1, 0, 0, 1);
    step(6'h1F, 2'b00, 8'h81, 5'h08, 1, 0, 0, 1);
    step(6'h0F, 2'b00, 8'h81, 5'h08, 1, 0, 0, 1);
    step(6'h07, 2'b00, 8'h81, 5'h08, 1, 0, 0, 1);
    step(6'h03, 2'b00, 8'h81, 5'h08, 1, 0, 0, 1);
    // R2 special receive
    step(6'h20, 2'b10, 8'h00, 5'h08, 1, 0, 0, 1);
    step(6'h04, 2'b01, 8'h00, 5'h08, 1, 0, 0, 1);
    step(6'h04, 2'b10, 8'h00, 5'h08, 1, 0, 0, 1);
    // R4 channel A unmodified; channel B modified with include-status clear
    step(6'h10, 2'b00, 8'h5A, 5'h08, 1, 0, 0, 0);
    step(6'h10, 2'b00, 8'h5A, 5'h08, 1, 0, 0, 1);
    // R6 master enable off, enable-in low
    step(6'h3F, 2'b00, 8'h00, 5'h00, 1, 0, 0, 1);
    step(6'h3F, 2'b00, 8'h00, 5'h08, 0, 0, 0, 1);
    // R11 disable lower chain with nothing pending
    step(6'h00, 2'b00, 8'h00, 5'h0C, 1, 0, 0, 1);
    // R7 ack B receive, then lower blocked, higher still requests
    step(6'h04, 2'b00, 8'h00, 5'h09, 1, 1, 0, 1);
    step(6'h07, 2'b00, 8'h00, 5'h09, 1, 0, 0, 1);
    step(6'h0F, 2'b00, 8'h00, 5'h09, 1, 0, 0, 1);
    // R8 ack A ext together with clearing B receive level
    step(6'h0F, 2'b00, 8'h00, 5'h09, 1, 1, 1, 1);
    step(6'h07, 2'b00, 8'h00, 5'h09, 1, 0, 0, 1);
    step(6'h07, 2'b00, 8'h00, 5'h09, 1, 0, 1, 1);
    step(6'h07, 2'b00, 8'h00, 5'h09, 1, 0, 0, 1);
    // R9 no-vector suppress, include status off
    step(6'h02, 2'b00, 8'hC3, 5'h0A, 1, 1, 0, 1);
    step(6'h00, 2'b00, 8'hC3, 5'h08, 1, 0, 1, 1);
    step(6'h02, 2'b00, 8'hC3, 5'h08, 1, 1, 0, 1);
    step(6'h00, 2'b00, 8'hC3, 5'h08, 1, 0, 1, 1);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      bit [31:0] r = $urandom;
      step(r[5:0], r[7:6], r[15:8], {r[20:19], r[18] & r[17], 2'b00} | 5'h08 | 5'(r[16]),
           r[21] | r[22], r[23] & r[24], r[25] & r[26] & r[27], r[28]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule